// File: doc/BRIEF.md
# Dual-Edge Input Capture Unit

This block time-stamps transitions of one external input against a free-running counter. The input first goes through an optional inversion and an enable gate. It is then synchronised into the clock domain and edge-detected. A rising edge copies the counter into one data register and a falling edge copies it into a second data register. Each of these captures sets a sticky flag for its own edge.

Software clears a flag by pulsing that edge's clear input. If a capture lands while its flag is still set, an overrun bit is raised. That overrun bit is dropped by the same clear pulse that drops the flag. Either edge can also ask the external counter to reload. It does this through a one-cycle request pulse, so the unit can measure period or pulse width directly.

Top module: `dual_edge_capture`

## Requirements
- R1: While `path_en` is 0 the conditioned input is held at 0, so pin transitions produce no capture.
- R2: While `cap_en` is 0 no edge changes either data register or either flag, and no reload request is issued.
- R3: A rising edge of the conditioned input stores `cnt_val` into `rise_data` and a falling edge stores it into `fall_data`. The store happens on the third rising clock edge after the input changes: two synchroniser stages, then the capture register.
- R4: With `invert` at 1 the pin is complemented before edge detection, so a high-to-low pin transition is captured as a rising edge.
- R5: When an edge is captured and that edge's reload enable is 1, `reload_req` is 1 for exactly the cycle in which the capture data appears.
- R6: A capture of an edge whose flag is already set raises that edge's overrun bit.
- R7: Every capture writes its data register, even when it also raises overrun.
- R8: A 1 on `rise_clr` or `fall_clr` clears that edge's flag and overrun bit on the next clock edge.
- R9: If a capture and a clear of the same edge fall on the same clock edge, the flag ends at 1 and the overrun bit ends at 0.
- R10: Reset (`rst_n` low) sets both data registers to 0 and sets every flag, overrun bit and `reload_req` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_pin | input | 1 | Raw asynchronous capture input |
| cnt_val | input | CNT_W | Current value of the time-base counter |
| path_en | input | 1 | Input path enable; when 0 the input is forced to 0 |
| cap_en | input | 1 | Capture enable |
| invert | input | 1 | Complement the pin before edge detection |
| rise_reload_en | input | 1 | Rising captures request a counter reload |
| fall_reload_en | input | 1 | Falling captures request a counter reload |
| rise_clr | input | 1 | Clear pulse for the rising flag and rising overrun |
| fall_clr | input | 1 | Clear pulse for the falling flag and falling overrun |
| rise_data | output | CNT_W | Counter value at the latest rising capture |
| fall_data | output | CNT_W | Counter value at the latest falling capture |
| rise_flag | output | 1 | Sticky rising-capture flag |
| fall_flag | output | 1 | Sticky falling-capture flag |
| rise_ovr | output | 1 | Rising overrun status |
| fall_ovr | output | 1 | Falling overrun status |
| reload_req | output | 1 | One-cycle counter reload request |

## Verification
A wrong remembered input level in the edge detector shows up at the ports as a capture in the wrong register, or as a missing capture. That error is visible exactly three clock edges after the pin moves. A stale flag shows up as an overrun bit that stays 0 when it should rise, or rises when it should not, on the next capture of that edge. Every check is therefore taken just after the third clock edge of each step. Overrun cases are built from two captures of the same edge with no clear in between, and the priority case puts the clear on the very cycle of the capture.

// File: rtl/cap_pkg.sv
package cap_pkg;
    localparam int NUM_EDGES = 2;
    localparam int IDX_RISE  = 0;
    localparam int IDX_FALL  = 1;
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES > 1) begin : g_multi
            always_comb chain_d = {chain_q[LAST-1:0], d_i};
        end else begin : g_single
            always_comb chain_d = d_i;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[LAST];
endmodule

// File: rtl/cap_edge_det.sv
module cap_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = level_i;
        rise_o = level_i & ~prev_q;
        fall_o = ~level_i & prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/cap_latch.sv
module cap_latch #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             event_i,
    input  logic             clr_i,
    input  logic             reload_en_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] data_o,
    output logic             flag_o,
    output logic             ovr_o,
    output logic             reload_o
);
    typedef struct packed {
        logic [CNT_W-1:0] data;
        logic             flag;
        logic             ovr;
        logic             reload;
    } latch_st_t;

    latch_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.reload = 1'b0;
        if (clr_i) begin
            st_d.flag = 1'b0;
            st_d.ovr  = 1'b0;
        end
        if (event_i) begin
            st_d.data   = cnt_i;
            st_d.flag   = 1'b1;
            st_d.reload = reload_en_i;
            if (st_q.flag && !clr_i) st_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o   = st_q.data;
    assign flag_o   = st_q.flag;
    assign ovr_o    = st_q.ovr;
    assign reload_o = st_q.reload;
endmodule

// File: rtl/dual_edge_capture.sv
module dual_edge_capture #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_pin,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             path_en,
    input  logic             cap_en,
    input  logic             invert,
    input  logic             rise_reload_en,
    input  logic             fall_reload_en,
    input  logic             rise_clr,
    input  logic             fall_clr,
    output logic [CNT_W-1:0] rise_data,
    output logic [CNT_W-1:0] fall_data,
    output logic             rise_flag,
    output logic             fall_flag,
    output logic             rise_ovr,
    output logic             fall_ovr,
    output logic             reload_req
);
    import cap_pkg::*;

    logic cond_raw, cond_sync, edge_rise, edge_fall;
    logic [NUM_EDGES-1:0] ev, clr, rel_en, flag, ovr, rel;
    logic [CNT_W-1:0]     data [NUM_EDGES];

    // gate and polarity applied ahead of the synchroniser: uniform latency
    assign cond_raw = path_en & (cap_pin ^ invert);

    cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(cond_raw), .q_o(cond_sync)
    );

    cap_edge_det u_edge (
        .clk(clk), .rst_n(rst_n), .level_i(cond_sync),
        .rise_o(edge_rise), .fall_o(edge_fall)
    );

    assign ev[IDX_RISE]     = edge_rise & cap_en;
    assign ev[IDX_FALL]     = edge_fall & cap_en;
    assign clr[IDX_RISE]    = rise_clr;
    assign clr[IDX_FALL]    = fall_clr;
    assign rel_en[IDX_RISE] = rise_reload_en;
    assign rel_en[IDX_FALL] = fall_reload_en;

    generate
        for (genvar e = 0; e < NUM_EDGES; e++) begin : g_edge
            cap_latch #(.CNT_W(CNT_W)) u_latch (
                .clk(clk), .rst_n(rst_n),
                .event_i(ev[e]), .clr_i(clr[e]), .reload_en_i(rel_en[e]),
                .cnt_i(cnt_val),
                .data_o(data[e]), .flag_o(flag[e]), .ovr_o(ovr[e]),
                .reload_o(rel[e])
            );
        end
    endgenerate

    assign rise_data  = data[IDX_RISE];
    assign fall_data  = data[IDX_FALL];
    assign rise_flag  = flag[IDX_RISE];
    assign fall_flag  = flag[IDX_FALL];
    assign rise_ovr   = ovr[IDX_RISE];
    assign fall_ovr   = ovr[IDX_FALL];
    assign reload_req = |rel;
endmodule

// File: rtl/dual_edge_capture_chk.sv
module dual_edge_capture_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cap_en,
    input logic             rise_clr,
    input logic             fall_clr,
    input logic [CNT_W-1:0] rise_data,
    input logic [CNT_W-1:0] fall_data,
    input logic             rise_flag,
    input logic             fall_flag,
    input logic             rise_ovr,
    input logic             fall_ovr,
    input logic             reload_req
);
    assert_rise_ovr_has_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rise_ovr |-> rise_flag);
    assert_fall_ovr_has_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fall_ovr |-> fall_flag);
    assert_rise_clear_drops_ovr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rise_clr |=> !rise_ovr);
    assert_fall_clear_drops_ovr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fall_clr |=> !fall_ovr);
    assert_capture_off_holds_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> ($stable(rise_data) && $stable(fall_data)));
    assert_reload_with_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reload_req |-> (rise_flag || fall_flag));
    assert_rise_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_flag && !rise_clr) |=> rise_flag);
    assert_fall_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_flag && !fall_clr) |=> fall_flag);
endmodule

bind dual_edge_capture dual_edge_capture_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en),
    .rise_clr(rise_clr), .fall_clr(fall_clr),
    .rise_data(rise_data), .fall_data(fall_data),
    .rise_flag(rise_flag), .fall_flag(fall_flag),
    .rise_ovr(rise_ovr), .fall_ovr(fall_ovr),
    .reload_req(reload_req)
);

// File: tb/dual_edge_capture_tb_top.sv
`timescale 1ns/1ps
module dual_edge_capture_tb_top;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cap_pin = 1'b0, path_en = 1'b0, cap_en = 1'b0, invert = 1'b0;
    logic rise_reload_en = 1'b0, fall_reload_en = 1'b0, rise_clr = 1'b0, fall_clr = 1'b0;
    logic [W-1:0] cnt_val = '0;
    logic [W-1:0] rise_data, fall_data;
    logic rise_flag, fall_flag, rise_ovr, fall_ovr, reload_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    dual_edge_capture #(.CNT_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .cnt_val(cnt_val),
        .path_en(path_en), .cap_en(cap_en), .invert(invert),
        .rise_reload_en(rise_reload_en), .fall_reload_en(fall_reload_en),
        .rise_clr(rise_clr), .fall_clr(fall_clr),
        .rise_data(rise_data), .fall_data(fall_data),
        .rise_flag(rise_flag), .fall_flag(fall_flag),
        .rise_ovr(rise_ovr), .fall_ovr(fall_ovr), .reload_req(reload_req)
    );

    typedef struct packed {
        logic pin, path, cap, inv, rre, fre, clr_r, clr_f;
        logic [W-1:0] cnt, e_rdata, e_fdata;
        logic e_rflag, e_fflag, e_rovr, e_fovr, e_rel;
    } vec_t;

    //  pin path cap inv rre fre clrR clrF  cnt       rdata     fdata   rf fo ro fo rel
    localparam vec_t VECS [12] = '{
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 16'h0100, 16'h0100, 16'h0000, 1'b1,1'b0,1'b0,1'b0,1'b0}, // R3 rise
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 16'h0200, 16'h0100, 16'h0200, 1'b1,1'b1,1'b0,1'b0,1'b0}, // R3 fall
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 16'h0300, 16'h0300, 16'h0200, 1'b1,1'b1,1'b1,1'b0,1'b0}, // R6 R7
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 16'h0350, 16'h0300, 16'h0200, 1'b0,1'b1,1'b0,1'b0,1'b0}, // R8
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 16'h0400, 16'h0300, 16'h0400, 1'b0,1'b1,1'b0,1'b1,1'b1}, // R5 R6
        '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1, 16'h0500, 16'h0500, 16'h0400, 1'b1,1'b0,1'b0,1'b0,1'b1}, // R5 R8
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 16'h0600, 16'h0500, 16'h0400, 1'b1,1'b0,1'b0,1'b0,1'b0}, // R2
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 16'h0700, 16'h0500, 16'h0400, 1'b1,1'b0,1'b0,1'b0,1'b0}, // R1
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 16'h0800, 16'h0800, 16'h0400, 1'b1,1'b0,1'b1,1'b0,1'b0}, // R6 R7
        '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 16'h0900, 16'h0800, 16'h0900, 1'b1,1'b1,1'b1,1'b0,1'b0}, // R4
        '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 16'h0A00, 16'h0A00, 16'h0900, 1'b1,1'b1,1'b1,1'b0,1'b1}, // R4 R5
        '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1, 16'h0B00, 16'h0A00, 16'h0900, 1'b0,1'b0,1'b0,1'b0,1'b0}  // R8
    };

    task automatic compare(input string tag, input vec_t v);
        logic [2*W+4:0] act, exp;
        act = {rise_data, fall_data, rise_flag, fall_flag, rise_ovr, fall_ovr, reload_req};
        exp = {v.e_rdata, v.e_fdata, v.e_rflag, v.e_fflag, v.e_rovr, v.e_fovr, v.e_rel};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual rdata=%h fdata=%h rf=%b ff=%b ro=%b fo=%b rel=%b expected rdata=%h fdata=%h rf=%b ff=%b ro=%b fo=%b rel=%b",
                tag, rise_data, fall_data, rise_flag, fall_flag, rise_ovr, fall_ovr, reload_req,
                v.e_rdata, v.e_fdata, v.e_rflag, v.e_fflag, v.e_rovr, v.e_fovr, v.e_rel);
        end
    endtask

    // drive at a falling clock edge; clear pulse sits on clock edge clr_at (1..3);
    // the capture lands on edge 3 and is checked at the falling edge after it
    task automatic run(input string tag, input vec_t v, input int clr_at);
        cap_pin = v.pin; path_en = v.path; cap_en = v.cap; invert = v.inv;
        rise_reload_en = v.rre; fall_reload_en = v.fre; cnt_val = v.cnt;
        for (int i = 1; i <= 3; i++) begin
            rise_clr = (i == clr_at) ? v.clr_r : 1'b0;
            fall_clr = (i == clr_at) ? v.clr_f : 1'b0;
            @(posedge clk);
            @(negedge clk);
        end
        rise_clr = 1'b0;
        fall_clr = 1'b0;
        compare(tag, v);
    endtask

    initial begin
        vec_t z;
        z = '0;
        repeat (2) @(negedge clk);
        compare("R10 reset state", z);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < 12; k++) begin
            run($sformatf("vector %0d", k), VECS[k], 1);
        end

        // R9: set beats clear on the same edge
        run("R3 fall setup", '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 16'h0C00,
                               16'h0A00,16'h0C00,1'b0,1'b1,1'b0,1'b0,1'b0}, 1);
        run("R3 rise setup", '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 16'h0C80,
                               16'h0C80,16'h0C00,1'b1,1'b1,1'b0,1'b0,1'b0}, 1);
        run("R9 set over clear", '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 16'h0D00,
                                   16'h0C80,16'h0D00,1'b1,1'b1,1'b0,1'b0,1'b0}, 3);

        // R10: reset in mid run
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        compare("R10 mid-run reset", z);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual run still active, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule